// File: doc/BRIEF.md
# MDIO PHY Auto-Polling Manager

This block owns a two-wire serial management bus (MDC clock and bidirectional MDIO data) shared by the PHYs of a multi-port switch. Whenever it is allowed to, it walks the ports in round-robin order. For each port it reads the PHY's status register and then its control register, and it keeps a per-port copy of link state, speed and duplex so the MACs can be set to match the link.

A host can issue a single read or write to any register of any PHY address. The request is latched, the host sees a busy flag, and at the next frame boundary the request takes the bus ahead of the next poll. Completion is signalled by a one-cycle done pulse, which comes with the read data.

Polling can be stopped for every port with one disable input, or for single ports with an exclusion mask. A base-select input decides whether port n talks to PHY address n or n+1.

Top module: `mdio_poll_mgr`

## Requirements
- R1: Each bus transaction is a 64-bit frame sent MSB first: 32 ones, start bits 01, opcode (10 read, 01 write), 5-bit PHY address, 5-bit register address, 2 turnaround bits (10 when writing), then 16 data bits.
- R2: MDC has a period of 2*MDC_HALF system clocks. MDIO driven by the block changes only just after a falling MDC edge.
- R3: In a read frame the block releases MDIO (output enable low) from the turnaround through the end of the data bits. It captures the PHY's data on rising MDC edges.
- R4: Polling visits ports in ascending order and wraps to port 0. Each visit reads register 1 and then register 0 at PHY address port + base_one_i.
- R5: link_o[n] is bit 2 of register 1. speed_o[n] is bit 13 of register 0. duplex_o[n] is bit 8 of register 0.
- R6: A port whose poll_mask_i bit is set is not polled, and its status outputs hold their values. Other ports keep being polled.
- R7: While poll_dis_i is high, no poll frame starts and all status outputs hold. Host requests are still served.
- R8: An accepted host request raises host_busy_o until completion. Completion is one host_done_o pulse in the cycle busy falls. For reads, host_rdata_o then holds the 16 data bits.
- R9: A pending host request is granted at the next frame boundary, before any further poll frame.
- R10: After reset, MDC is low, MDIO is released, host_busy_o is low and every status bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| poll_dis_i | input | 1 | Stops automatic polling on all ports |
| poll_mask_i | input | NUM_PORTS | Per-port polling exclusion |
| base_one_i | input | 1 | PHY address = port + 1 when high, = port when low |
| host_req_i | input | 1 | Host request, accepted when host_busy_o is low |
| host_wr_i | input | 1 | Request is a write (1) or a read (0) |
| host_phy_i | input | 5 | Target PHY address |
| host_reg_i | input | 5 | Target register address |
| host_wdata_i | input | 16 | Write data |
| host_busy_o | output | 1 | Request accepted and not yet finished |
| host_done_o | output | 1 | One-cycle completion pulse |
| host_rdata_o | output | 16 | Read data, valid at host_done_o |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| link_o | output | NUM_PORTS | Per-port link status |
| speed_o | output | NUM_PORTS | Per-port speed (1 = 100 Mb/s) |
| duplex_o | output | NUM_PORTS | Per-port duplex (1 = full) |

## Verification
The bench builds the block with NUM_PORTS=4 and MDC_HALF=2. MDC then runs at a quarter of the system clock and one frame takes about 256 cycles, so several full polling rounds, each eight frames long, fit in a short run. With four ports, switching the address base moves every port onto a PHY with a different link value, and masking one port shows a visible split between held and refreshed status. A behavioural PHY on the shared line checks the framing, the turnaround ownership and the host priority latency.

// File: rtl/mdio_poll_pkg.sv
package mdio_poll_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;

  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [4:0] REG_CTRL = 5'd0;
  localparam logic [4:0] REG_STAT = 5'd1;

  typedef enum logic [0:0] {SCH_IDLE, SCH_WAIT} sch_state_e;

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int MDC_HALF = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mdc_o,
  output logic rise_p_o,
  output logic fall_p_o
);
  localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(MDC_HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      mdc_o    <= 1'b0;
      rise_p_o <= 1'b0;
      fall_p_o <= 1'b0;
    end else begin
      rise_p_o <= 1'b0;
      fall_p_o <= 1'b0;
      if (cnt_q == LAST) begin
        cnt_q    <= '0;
        mdc_o    <= ~mdc_o;
        rise_p_o <= ~mdc_o;
        fall_p_o <= mdc_o;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r2_rise_marks_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> rise_p_o);
  a_r2_fall_marks_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdc_o) |-> fall_p_o);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng import mdio_poll_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rise_p_i,
  input  logic        fall_p_i,
  input  logic        start_i,
  input  mdio_cmd_t   cmd_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  localparam logic [6:0] END_CNT = 7'(FRAME_BITS);

  logic [FRAME_BITS-1:0] sr_q;
  logic [6:0]            cnt_q;
  logic                  rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q      <= '0;
      cnt_q     <= '0;
      rd_q      <= 1'b0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      rdata_o   <= '0;
      mdio_o    <= 1'b1;
      mdio_oe_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        sr_q   <= {32'hFFFF_FFFF, 2'b01, (cmd_i.wr ? OP_WR : OP_RD), cmd_i.phy,
                   cmd_i.regad, 2'b10, (cmd_i.wr ? cmd_i.wdata : 16'h0000)};
        cnt_q  <= '0;
        rd_q   <= ~cmd_i.wr;
        busy_o <= 1'b1;
      end else if (busy_o && fall_p_i && cnt_q != END_CNT) begin
        mdio_o    <= sr_q[FRAME_BITS-1];
        // read frames hand the line to the PHY from turnaround on
        mdio_oe_o <= !(rd_q && cnt_q >= 7'(TA_POS));
        sr_q      <= {sr_q[FRAME_BITS-2:0], 1'b0};
        cnt_q     <= cnt_q + 1'b1;
      end else if (busy_o && rise_p_i) begin
        if (rd_q && cnt_q > 7'(DATA_POS))
          rdata_o <= {rdata_o[14:0], mdio_i};
        if (cnt_q == END_CNT) begin
          busy_o    <= 1'b0;
          done_o    <= 1'b1;
          mdio_oe_o <= 1'b0;
        end
      end
    end
  end

  a_r2_mdio_moves_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_o) |-> $past(fall_p_i));
  a_r3_released_while_sampling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rd_q && rise_p_i && cnt_q > 7'(DATA_POS)) |-> !mdio_oe_o);
  a_r1_frame_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(cnt_q) == END_CNT);
endmodule

// File: rtl/mdio_poll_sched.sv
module mdio_poll_sched import mdio_poll_pkg::*; #(
  parameter int NUM_PORTS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 poll_dis_i,
  input  logic [NUM_PORTS-1:0] poll_mask_i,
  input  logic                 base_one_i,
  input  logic                 host_req_i,
  input  logic                 host_wr_i,
  input  logic [4:0]           host_phy_i,
  input  logic [4:0]           host_reg_i,
  input  logic [15:0]          host_wdata_i,
  input  logic                 eng_busy_i,
  input  logic                 eng_done_i,
  input  logic [15:0]          eng_rdata_i,
  output logic                 eng_start_o,
  output mdio_cmd_t            eng_cmd_o,
  output logic                 host_busy_o,
  output logic                 host_done_o,
  output logic [15:0]          host_rdata_o,
  output logic [NUM_PORTS-1:0] link_o,
  output logic [NUM_PORTS-1:0] speed_o,
  output logic [NUM_PORTS-1:0] duplex_o
);
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam logic [PW-1:0] LAST_PORT = PW'(NUM_PORTS - 1);

  sch_state_e    state_q;
  logic [PW-1:0] port_q;
  logic          phase_q;   // 0: status register, 1: control register
  logic          sel_host_q;
  logic          pend_q;
  mdio_cmd_t     host_cmd_q;

  assign host_busy_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= SCH_IDLE;
      port_q       <= '0;
      phase_q      <= 1'b0;
      sel_host_q   <= 1'b0;
      pend_q       <= 1'b0;
      host_cmd_q   <= '0;
      eng_start_o  <= 1'b0;
      eng_cmd_o    <= '0;
      host_done_o  <= 1'b0;
      host_rdata_o <= '0;
      link_o       <= '0;
      speed_o      <= '0;
      duplex_o     <= '0;
    end else begin
      eng_start_o <= 1'b0;
      host_done_o <= 1'b0;
      if (host_req_i && !pend_q) begin
        pend_q     <= 1'b1;
        host_cmd_q <= '{wr: host_wr_i, phy: host_phy_i, regad: host_reg_i, wdata: host_wdata_i};
      end
      unique case (state_q)
        SCH_IDLE: if (!eng_busy_i) begin
          if (pend_q) begin
            eng_start_o <= 1'b1;
            eng_cmd_o   <= host_cmd_q;
            sel_host_q  <= 1'b1;
            state_q     <= SCH_WAIT;
          end else if (!poll_dis_i && !(&poll_mask_i)) begin
            if (poll_mask_i[port_q]) begin
              port_q  <= (port_q == LAST_PORT) ? '0 : port_q + 1'b1;
              phase_q <= 1'b0;
            end else begin
              eng_start_o <= 1'b1;
              eng_cmd_o   <= '{wr: 1'b0, phy: 5'(port_q) + {4'b0, base_one_i},
                               regad: (phase_q ? REG_CTRL : REG_STAT), wdata: 16'h0000};
              sel_host_q  <= 1'b0;
              state_q     <= SCH_WAIT;
            end
          end
        end
        SCH_WAIT: if (eng_done_i) begin
          state_q <= SCH_IDLE;
          if (sel_host_q) begin
            pend_q      <= 1'b0;
            host_done_o <= 1'b1;
            if (!host_cmd_q.wr) host_rdata_o <= eng_rdata_i;
          end else if (!phase_q) begin
            link_o[port_q] <= eng_rdata_i[2];
            phase_q        <= 1'b1;
          end else begin
            speed_o[port_q]  <= eng_rdata_i[13];
            duplex_o[port_q] <= eng_rdata_i[8];
            phase_q          <= 1'b0;
            port_q           <= (port_q == LAST_PORT) ? '0 : port_q + 1'b1;
          end
        end
        default: state_q <= SCH_IDLE;
      endcase
    end
  end

  a_r8_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_done_o |-> (!host_busy_o && $past(host_busy_o)));
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_done_o |=> !host_done_o);
  a_r9_host_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SCH_IDLE && !eng_busy_i && pend_q) |=> (eng_start_o && eng_cmd_o == $past(host_cmd_q)));
  a_r7_disabled_no_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SCH_IDLE && !pend_q && poll_dis_i) |=> !eng_start_o);
  a_r6_masked_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SCH_IDLE && !pend_q && poll_mask_i[port_q]) |=> !eng_start_o);
endmodule

// File: rtl/mdio_poll_mgr.sv
module mdio_poll_mgr import mdio_poll_pkg::*; #(
  parameter int NUM_PORTS = 8,
  parameter int MDC_HALF  = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 poll_dis_i,
  input  logic [NUM_PORTS-1:0] poll_mask_i,
  input  logic                 base_one_i,
  input  logic                 host_req_i,
  input  logic                 host_wr_i,
  input  logic [4:0]           host_phy_i,
  input  logic [4:0]           host_reg_i,
  input  logic [15:0]          host_wdata_i,
  output logic                 host_busy_o,
  output logic                 host_done_o,
  output logic [15:0]          host_rdata_o,
  output logic                 mdc_o,
  output logic                 mdio_o,
  output logic                 mdio_oe_o,
  input  logic                 mdio_i,
  output logic [NUM_PORTS-1:0] link_o,
  output logic [NUM_PORTS-1:0] speed_o,
  output logic [NUM_PORTS-1:0] duplex_o
);
  logic        rise_p, fall_p;
  logic        eng_start, eng_busy, eng_done;
  logic [15:0] eng_rdata;
  mdio_cmd_t   eng_cmd;

  mdio_clk_gen #(.MDC_HALF(MDC_HALF)) u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .mdc_o(mdc_o), .rise_p_o(rise_p), .fall_p_o(fall_p)
  );

  mdio_frame_eng u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_p_i(rise_p), .fall_p_i(fall_p),
    .start_i(eng_start), .cmd_i(eng_cmd), .mdio_i(mdio_i),
    .busy_o(eng_busy), .done_o(eng_done), .rdata_o(eng_rdata),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
  );

  mdio_poll_sched #(.NUM_PORTS(NUM_PORTS)) u_sched (
    .clk_i(clk_i), .rst_ni(rst_ni), .poll_dis_i(poll_dis_i), .poll_mask_i(poll_mask_i),
    .base_one_i(base_one_i), .host_req_i(host_req_i), .host_wr_i(host_wr_i),
    .host_phy_i(host_phy_i), .host_reg_i(host_reg_i), .host_wdata_i(host_wdata_i),
    .eng_busy_i(eng_busy), .eng_done_i(eng_done), .eng_rdata_i(eng_rdata),
    .eng_start_o(eng_start), .eng_cmd_o(eng_cmd), .host_busy_o(host_busy_o),
    .host_done_o(host_done_o), .host_rdata_o(host_rdata_o),
    .link_o(link_o), .speed_o(speed_o), .duplex_o(duplex_o)
  );

  a_r10_idle_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!mdio_oe_o && !host_busy_o));
endmodule

// File: tb/sim_mdio_poll_mgr.sv
module sim_mdio_poll_mgr;
  localparam int NP   = 4;
  localparam int HALF = 2;
  localparam int FRM  = 64 * 2 * HALF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          poll_dis = 1'b1, base_one = 1'b0;
  logic [NP-1:0] poll_mask = '0;
  logic          host_req = 1'b0, host_wr = 1'b0;
  logic [4:0]    host_phy = '0, host_reg = '0;
  logic [15:0]   host_wdata = '0;
  logic          host_busy, host_done, mdc, mdio_out, mdio_oe;
  logic [15:0]   host_rdata;
  logic [NP-1:0] link, speed, duplex;

  logic phy_oe = 1'b0, phy_d = 1'b1;
  wire  line = mdio_oe ? mdio_out : (phy_oe ? phy_d : 1'b1);

  mdio_poll_mgr #(.NUM_PORTS(NP), .MDC_HALF(HALF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .poll_dis_i(poll_dis), .poll_mask_i(poll_mask),
    .base_one_i(base_one), .host_req_i(host_req), .host_wr_i(host_wr),
    .host_phy_i(host_phy), .host_reg_i(host_reg), .host_wdata_i(host_wdata),
    .host_busy_o(host_busy), .host_done_o(host_done), .host_rdata_o(host_rdata),
    .mdc_o(mdc), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(line),
    .link_o(link), .speed_o(speed), .duplex_o(duplex)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic link_inv = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_link(int a, logic inv); return ~a[0] ^ inv; endfunction
  function automatic logic exp_spd(int a); return a[1]; endfunction
  function automatic logic exp_dup(int a); return a[0] ^ a[1]; endfunction

  function automatic logic [15:0] dflt_reg(int a, int r, logic inv);
    logic [15:0] v;
    if (r == 1) begin v = 16'h7809; v[2] = exp_link(a, inv); end
    else if (r == 0) begin v = 16'h1000; v[13] = exp_spd(a); v[8] = exp_dup(a); end
    else v = 16'hA000 | 16'(a << 5) | 16'(r);
    return v;
  endfunction

  // behavioural PHY
  logic [15:0] wr_mem [32][32];
  logic [1023:0] wr_valid = '0;
  int m_st = 0, m_cnt = 0, ones = 0, pre_ones = 0, frames = 0;
  logic [11:0] hdr;
  logic [1:0]  last_op = '0, last_ta = '0;
  logic [4:0]  last_phy = '0, last_reg = '0;
  logic [15:0] last_wd = '0, rd_val = '0, wd;
  logic pend_oe = 1'b0, pend_d = 1'b1, clash = 1'b0;

  always @(posedge mdc) begin
    if (mdio_oe && phy_oe) clash = 1'b1;
    case (m_st)
      0: if (line && mdio_oe) ones++;
         else begin
           if (!line && ones >= 32) begin m_st = 1; pre_ones = ones; end
           ones = 0;
         end
      1: begin m_st = line ? 2 : 0; m_cnt = 0; end
      2: begin
        hdr = {hdr[10:0], line}; m_cnt++;
        if (m_cnt == 12) begin
          last_op = hdr[11:10]; last_phy = hdr[9:5]; last_reg = hdr[4:0]; m_cnt = 0;
          if (last_op == 2'b10) begin
            m_st = 3; pend_oe = 1'b0;
            rd_val = wr_valid[{last_phy, last_reg}] ? wr_mem[last_phy][last_reg]
                   : dflt_reg(int'(last_phy), int'(last_reg), link_inv);
          end else if (last_op == 2'b01) m_st = 5;
          else m_st = 0;
        end
      end
      3: begin
        m_cnt++;
        if (m_cnt == 1) begin pend_oe = 1'b1; pend_d = 1'b0; end
        else begin pend_d = rd_val[15]; m_st = 4; m_cnt = 0; end
      end
      4: begin
        m_cnt++;
        if (m_cnt < 16) pend_d = rd_val[15 - m_cnt];
        else begin pend_oe = 1'b0; m_st = 0; ones = 0; frames++; end
      end
      5: begin
        last_ta = {last_ta[0], line}; m_cnt++;
        if (m_cnt == 2) begin m_st = 6; m_cnt = 0; end
      end
      default: begin
        wd = {wd[14:0], line}; m_cnt++;
        if (m_cnt == 16) begin
          wr_mem[last_phy][last_reg] = wd; wr_valid[{last_phy, last_reg}] = 1'b1;
          last_wd = wd; m_st = 0; ones = 0; frames++;
        end
      end
    endcase
  end

  always @(negedge mdc) begin phy_oe <= pend_oe; phy_d <= pend_d; end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_op(logic wr, logic [4:0] phy, logic [4:0] rg, logic [15:0] wdat,
                         output logic [15:0] rdat, output int lat);
    int t = 0;
    @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_phy = phy; host_reg = rg; host_wdata = wdat;
    @(negedge clk);
    chk("R8 busy after accept", 32'(host_busy), 32'd1);
    host_req = 1'b0;
    while (!host_done && t < 4 * FRM) begin @(negedge clk); t++; end
    chk("R8 done pulse seen", 32'(host_done), 32'd1);
    chk("R8 busy low with done", 32'(host_busy), 32'd0);
    rdat = host_rdata; lat = t;
    @(negedge clk);
    chk("R8 done one cycle", 32'(host_done), 32'd0);
  endtask

  task automatic t_reset();
    wait_clk(3);
    chk("R10 mdc low", 32'(mdc), 32'd0);
    chk("R10 mdio released", 32'(mdio_oe), 32'd0);
    chk("R10 busy low", 32'(host_busy), 32'd0);
    chk("R10 status zero", 32'({link, speed, duplex}), 32'd0);
    rst_n = 1'b1;
    wait_clk(3);
    chk("R10 status zero after release", 32'({link, speed, duplex}), 32'd0);
  endtask

  task automatic t_mdc_rate();
    int c = 0;
    logic prev = mdc;
    while (!(mdc && !prev)) begin prev = mdc; @(negedge clk); end
    prev = mdc; @(negedge clk);
    c = 1;
    while (!(mdc && !prev)) begin prev = mdc; @(negedge clk); c++; end
    chk("R2 mdc period", 32'(c), 32'(2 * HALF));
  endtask

  task automatic check_ports(string req, int base, logic inv, int skip);
    for (int p = 0; p < NP; p++) begin
      if (p == skip) continue;
      chk({req, " link"}, 32'(link[p]), 32'(exp_link(p + base, inv)));
      chk({req, " speed"}, 32'(speed[p]), 32'(exp_spd(p + base)));
      chk({req, " duplex"}, 32'(duplex[p]), 32'(exp_dup(p + base)));
    end
  endtask

  task automatic t_poll_base0();
    poll_dis = 1'b0; base_one = 1'b0;
    wait_clk(18 * FRM);
    check_ports("R4 R5 base0", 0, 1'b0, -1);
    chk("R1 preamble ones", 32'(pre_ones), 32'd32);
    chk("R1 poll opcode read", 32'(last_op), 32'h2);
    chk("R4 poll regs 0/1", 32'(last_reg <= 5'd1), 32'd1);
  endtask

  task automatic t_poll_base1();
    base_one = 1'b1;
    wait_clk(18 * FRM);
    check_ports("R4 base1", 1, 1'b0, -1);
  endtask

  task automatic t_mask();
    poll_mask = 4'b0100;
    link_inv = 1'b1;
    wait_clk(18 * FRM);
    check_ports("R6 unmasked refreshed", 1, 1'b1, 2);
    chk("R6 masked port held", 32'(link[2]), 32'(exp_link(3, 1'b0)));
    poll_mask = '0;
  endtask

  task automatic t_disable();
    logic [3*NP-1:0] snap;
    int f0, oe_hits = 0;
    poll_dis = 1'b1;
    wait_clk(2 * FRM);
    snap = {link, speed, duplex};
    f0 = frames;
    link_inv = 1'b0;
    for (int i = 0; i < 10 * FRM; i++) begin
      @(negedge clk);
      if (mdio_oe) oe_hits++;
    end
    chk("R7 no frames while disabled", 32'(frames - f0), 32'd0);
    chk("R7 line idle while disabled", 32'(oe_hits), 32'd0);
    chk("R7 status held", 32'({link, speed, duplex}), 32'(snap));
  endtask

  task automatic t_host_access();
    logic [15:0] rd;
    int lat;
    host_op(1'b1, 5'd5, 5'd9, 16'h1234, rd, lat);
    chk("R1 write opcode", 32'(last_op), 32'h1);
    chk("R1 write address", 32'({last_phy, last_reg}), 32'({5'd5, 5'd9}));
    chk("R1 write turnaround", 32'(last_ta), 32'h2);
    chk("R7 host write served while disabled", 32'(last_wd), 32'h1234);
    host_op(1'b0, 5'd5, 5'd9, 16'h0, rd, lat);
    chk("R8 read back", 32'(rd), 32'h1234);
    host_op(1'b0, 5'd31, 5'd31, 16'h0, rd, lat);
    chk("R3 read top address", 32'(rd), 32'hA3FF);
  endtask

  task automatic t_priority();
    logic [15:0] rd;
    int lat;
    poll_dis = 1'b0;
    wait_clk(3 * FRM + 37);
    host_op(1'b0, 5'd7, 5'd3, 16'h0, rd, lat);
    chk("R9 read data while polling", 32'(rd), 32'hA0E3);
    chk("R9 granted at next boundary", 32'(lat <= 2 * FRM + 40), 32'd1);
    wait_clk(18 * FRM);
    check_ports("R4 polling resumes", 1, 1'b0, -1);
    chk("R3 no bus contention", 32'(clash), 32'd0);
  endtask

  initial begin
    t_reset();
    t_mdc_rate();
    t_poll_base0();
    t_poll_base1();
    t_mask();
    t_disable();
    t_host_access();
    t_priority();
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule